// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block sits between a clocked request/acknowledge interface and an external asynchronous static RAM. The RAM holds 16-bit words, one of 524,288 selected by a 19-bit word address. Each 8-bit half of a word has its own active-low strobe. The controller accepts one read or write command at a time. It drives the memory's active-low chip enable, output enable, write enable and the two lane strobes. It holds every command in wait states until the memory's access times have passed.

Every timing figure is a parameter in nanoseconds. The controller turns each one into a cycle count by rounding up against the clock-period parameter. The defaults give a 55 ns read grade at a 5 ns clock. The bidirectional data pins are split into an output word, an output-drive enable and an input word, so that the pad ring can join them. The controller drives the data bus only while it writes. Before it drives, it waits long enough for the memory's outputs to go to high impedance.

Top module: `sram_port_ctl`

## Requirements
- R1: Reset leaves the memory idle: mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n and mem_ub_n are high, mem_dq_oe and rsp_ack are low, and req_ready is high.
- R2: A read keeps mem_ce_n and mem_oe_n low and mem_we_n high for exactly RD_CYC cycles. RD_CYC is the largest of the rounded-up address, chip-select, lane-strobe and output-enable access times, which is 11 by default. The following cycle has rsp_ack high with mem_ce_n and mem_oe_n back high.
- R3: For reads, req_be[0] enables the lower lane (mem_lb_n low, data bits 7:0) and req_be[1] enables the upper lane (mem_ub_n low, bits 15:8). rsp_rdata carries the memory word sampled on the last access cycle, with every lane that is not enabled returned as zero.
- R4: A write first spends TURN_CYC cycles with mem_ce_n low, mem_oe_n and mem_we_n high and mem_dq_oe low. TURN_CYC is the rounded-up output-disable time, 5 by default. Next, mem_we_n is low for WP_CYC cycles (rounded-up write pulse, 9 by default), with mem_dq_oe high and mem_dq_out equal to the write data. Then comes one cycle with mem_we_n high, mem_dq_oe still high and rsp_ack high. After that, mem_dq_oe is low.
- R5: During a write, a lane strobe is low only while mem_we_n is low and only for lanes whose req_be bit is set. Both strobes are high in the turnaround and hold cycles.
- R6: mem_oe_n is never low while mem_we_n is low or mem_dq_oe is high. mem_dq_oe first rises only after mem_oe_n has been high for at least TURN_CYC cycles.
- R7: mem_addr and mem_dq_out take the command's values from the cycle after acceptance. They do not change while mem_we_n is low.
- R8: req_ready is high only when the controller is idle. A command is accepted on a clock edge with req_valid and req_ready both high. A req_valid pulse while req_ready is low is ignored: it starts no memory cycle.
- R9: mem_ce_n is high whenever req_ready is high, so the memory is in standby between commands.
- R10: rsp_ack is high for exactly one cycle per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Controller idle, command will be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 lower, bit 1 upper |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_ack on reads |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_dq_out | output | 16 | Data driven to the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
Cycle offsets are counted from the clock edge that accepts a command. For a read, the access controls are visible for cycles 0 to 10 and rsp_ack in cycle 11. For a write, the turnaround covers cycles 0 to 4, the write pulse cycles 5 to 13, and the acknowledge with the driver still on cycle 14. Both commands show req_ready again one cycle after the acknowledge. The bench samples on falling edges and numbers each sample by its offset, so every length and position is compared with the exact offset the requirement gives. The memory model in the bench returns correct data only once the rounded-up access time has elapsed, so a shortened wait shows up as wrong read data.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_DONE,
    ST_WR_TURN,
    ST_WR_PULSE,
    ST_WR_HOLD
  } port_state_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int unsigned MAX_COUNT = 16,
  localparam int unsigned CW = $clog2(MAX_COUNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // last cycle of the loaded window
  assign expired = (cnt_q == CW'(1));

endmodule

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW = LANES * LANE_W
) (
  input  logic [LANES-1:0] lane_en,
  input  logic             active,
  input  logic [DW-1:0]    din_raw,
  output logic [LANES-1:0] strobe_n,
  output logic [DW-1:0]    din_masked
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign strobe_n[g] = ~(active & lane_en[g]);
    assign din_masked[g*LANE_W +: LANE_W] =
      lane_en[g] ? din_raw[g*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/sram_port_ctl.sv
module sram_port_ctl
  import sram_port_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned T_CLK_NS  = 5,
  parameter int unsigned T_AA_NS   = 55,
  parameter int unsigned T_ACS_NS  = 55,
  parameter int unsigned T_BA_NS   = 30,
  parameter int unsigned T_OE_NS   = 30,
  parameter int unsigned T_OHZ_NS  = 25,
  parameter int unsigned T_WP_NS   = 42,
  localparam int unsigned LANES    = 2,
  localparam int unsigned DATA_W   = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned RD_CYC   = max_u(max_u(ns_to_cyc(T_AA_NS, T_CLK_NS), ns_to_cyc(T_ACS_NS, T_CLK_NS)),
                                           max_u(ns_to_cyc(T_BA_NS, T_CLK_NS), ns_to_cyc(T_OE_NS, T_CLK_NS)));
  localparam int unsigned TURN_CYC = ns_to_cyc(T_OHZ_NS, T_CLK_NS);
  localparam int unsigned WP_CYC   = ns_to_cyc(T_WP_NS, T_CLK_NS);
  localparam int unsigned MAX_CYC  = max_u(RD_CYC, max_u(TURN_CYC, WP_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // sequencing
  port_state_e      state_q, state_d;
  logic             accept;
  logic             capture;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;

  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = ST_WR_TURN;
            tmr_val = CNT_W'(TURN_CYC);
          end else begin
            state_d = ST_RD_ACC;
            tmr_val = CNT_W'(RD_CYC);
          end
        end
      end
      ST_RD_ACC: begin
        if (tmr_expired) begin
          capture = 1'b1;
          state_d = ST_RD_DONE;
        end
      end
      ST_RD_DONE: state_d = ST_IDLE;
      ST_WR_TURN: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WP_CYC);
          state_d  = ST_WR_PULSE;
        end
      end
      ST_WR_PULSE: begin
        if (tmr_expired) begin
          state_d = ST_WR_HOLD;
        end
      end
      ST_WR_HOLD: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  sram_wait_timer #(
    .MAX_COUNT (MAX_CYC)
  ) i_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  // command holding registers
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q, be_d;

  assign be_d = accept ? req_be : be_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  // lane strobes and read masking
  logic             lanes_active_d;
  logic [LANES-1:0] strobe_n_d;
  logic [LANES-1:0] unused_strobe_cur;
  logic [DATA_W-1:0] din_masked;
  logic [DATA_W-1:0] unused_mask_nxt;

  assign lanes_active_d = (state_d == ST_RD_ACC) || (state_d == ST_WR_PULSE);

  sram_lane_gate #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) i_lane_next (
    .lane_en    (be_d),
    .active     (lanes_active_d),
    .din_raw    (mem_dq_in),
    .strobe_n   (strobe_n_d),
    .din_masked (unused_mask_nxt)
  );

  sram_lane_gate #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) i_lane_read (
    .lane_en    (be_q),
    .active     (1'b1),
    .din_raw    (mem_dq_in),
    .strobe_n   (unused_strobe_cur),
    .din_masked (din_masked)
  );

  // memory-side controls registered from the next state
  logic ce_n_q, oe_n_q, we_n_q, dq_oe_q, ack_q, ready_q;
  logic [LANES-1:0] strobe_n_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= ST_IDLE;
      ce_n_q     <= 1'b1;
      oe_n_q     <= 1'b1;
      we_n_q     <= 1'b1;
      dq_oe_q    <= 1'b0;
      ack_q      <= 1'b0;
      ready_q    <= 1'b1;
      strobe_n_q <= '1;
    end else begin
      state_q    <= state_d;
      ce_n_q     <= (state_d == ST_IDLE) || (state_d == ST_RD_DONE);
      oe_n_q     <= (state_d != ST_RD_ACC);
      we_n_q     <= (state_d != ST_WR_PULSE);
      dq_oe_q    <= (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
      ack_q      <= (state_d == ST_RD_DONE) || (state_d == ST_WR_HOLD);
      ready_q    <= (state_d == ST_IDLE);
      strobe_n_q <= strobe_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= din_masked;
    end
  end

  assign req_ready  = ready_q;
  assign rsp_ack    = ack_q;
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_ce_n   = ce_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_dq_oe  = dq_oe_q;
  assign mem_lb_n   = strobe_n_q[0];
  assign mem_ub_n   = strobe_n_q[1];

  // checks

  // cycles for which output enable has been high, saturating
  logic [CNT_W-1:0] hz_cnt_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hz_cnt_q <= '0;
    end else if (!mem_oe_n) begin
      hz_cnt_q <= '0;
    end else if (hz_cnt_q != CNT_W'(TURN_CYC)) begin
      hz_cnt_q <= hz_cnt_q + 1'b1;
    end
  end

  a_r6_no_oe_with_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(mem_dq_oe) |-> (hz_cnt_q >= CNT_W'(TURN_CYC)));

  a_r4_drive_in_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(mem_we_n) |=> !mem_dq_oe);

  a_r7_stable_in_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  a_r5_lanes_closed: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!mem_ce_n && mem_oe_n && mem_we_n) |-> (mem_lb_n && mem_ub_n));

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_ready && req_valid) |=> !req_ready);

  a_r9_standby_when_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_ready |-> mem_ce_n);

  a_r10_single_ack: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_ack |=> !rsp_ack);

endmodule

// File: tb/test_sram_port_ctl.sv
module test_sram_port_ctl;

  localparam int CLK_NS = 5;
  // expected cycle counts from R2 and R4
  localparam int RD_E   = 11;   // max(ceil(55/5), ceil(55/5), ceil(30/5), ceil(30/5))
  localparam int TURN_E = 5;    // ceil(25/5)
  localparam int WP_E   = 9;    // ceil(42/5)

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [18:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        rsp_ack;
  logic [15:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in;

  int total;
  int bad;
  int cyc;

  sram_port_ctl i_sram_port_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .rsp_ack    (rsp_ack),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_lb_n   (mem_lb_n),
    .mem_ub_n   (mem_ub_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in)
  );

  initial clk = 1'b0;
  always #(CLK_NS / 2.0) clk = ~clk;

  // memory model: 64 words indexed by the low address bits
  logic [15:0] mem [64];
  logic [15:0] shadow [64];
  int          rd_cnt;

  function automatic logic [15:0] init_word(input int i);
    return 16'(i * 16'h0307) ^ 16'h5A3C;
  endfunction

  always @(posedge clk) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_cnt <= rd_cnt + 1;
    else rd_cnt <= 0;
    if (!mem_ce_n && !mem_we_n) begin
      if (!mem_lb_n) mem[mem_addr[5:0]][7:0]  <= mem_dq_oe ? mem_dq_out[7:0]  : 8'hEE;
      if (!mem_ub_n) mem[mem_addr[5:0]][15:8] <= mem_dq_oe ? mem_dq_out[15:8] : 8'hEE;
    end
  end

  // data becomes valid once the access time has elapsed at the sampling edge
  always_comb begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n && rd_cnt >= RD_E - 1)
      mem_dq_in = {mem_ub_n ? 8'hA5 : mem[mem_addr[5:0]][15:8],
                   mem_lb_n ? 8'h5A : mem[mem_addr[5:0]][7:0]};
    else
      mem_dq_in = 16'hDEAD;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_cmd(input bit wr, input logic [18:0] a, input logic [15:0] wd,
                        input logic [1:0] be, input bit inject);
    int  k;
    int  acc_len, turn_len, wp_len;
    bit  seen_we, ack_seen;
    logic [15:0] exp_rd;
    @(negedge clk);
    chk(req_ready, "R8 ready before command", 32'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    acc_len = 0; turn_len = 0; wp_len = 0; seen_we = 0; ack_seen = 0;
    for (k = 0; k < 40; k++) begin
      if (inject && k == 3) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 19'h00011; req_be = 2'b11;
      end
      if (inject && k == 4) req_valid = 1'b0;
      if (rsp_ack) begin ack_seen = 1; break; end
      chk(!req_ready, "R8 busy", 32'(req_ready), 0);
      chk(!mem_ce_n && mem_addr == a, "R7 address held", 32'(mem_addr), 32'(a));
      if (!wr) begin
        if (!mem_oe_n && mem_we_n) acc_len++;
        chk(mem_lb_n == !be[0] && mem_ub_n == !be[1], "R3 read lane strobes",
            32'({mem_ub_n, mem_lb_n}), 32'(~be));
      end else begin
        chk(mem_oe_n, "R6 oe high in write", 32'(mem_oe_n), 1);
        if (mem_we_n) begin
          if (!seen_we) turn_len++;
          chk(!mem_dq_oe && mem_lb_n && mem_ub_n, "R4 turnaround idle bus",
              32'({mem_dq_oe, mem_lb_n, mem_ub_n}), 32'(3'b011));
        end else begin
          seen_we = 1; wp_len++;
          chk(mem_dq_oe && mem_dq_out == wd, "R4 data driven", 32'(mem_dq_out), 32'(wd));
          chk(mem_lb_n == !be[0] && mem_ub_n == !be[1], "R5 write lane strobes",
              32'({mem_ub_n, mem_lb_n}), 32'(~be));
        end
      end
      @(negedge clk);
    end
    chk(ack_seen, "R10 ack arrives", 32'(ack_seen), 1);
    if (!wr) begin
      chk(k == RD_E, "R2 ack offset", 32'(k), RD_E);
      chk(acc_len == RD_E, "R2 access length", 32'(acc_len), RD_E);
      chk(mem_ce_n && mem_oe_n, "R2 controls released at ack", 32'({mem_ce_n, mem_oe_n}), 3);
      exp_rd = {be[1] ? shadow[a[5:0]][15:8] : 8'h00, be[0] ? shadow[a[5:0]][7:0] : 8'h00};
      chk(rsp_rdata == exp_rd, "R3 read data", 32'(rsp_rdata), 32'(exp_rd));
    end else begin
      chk(k == TURN_E + WP_E, "R4 ack offset", 32'(k), TURN_E + WP_E);
      chk(turn_len == TURN_E, "R4 turnaround length", 32'(turn_len), TURN_E);
      chk(wp_len == WP_E, "R4 write pulse length", 32'(wp_len), WP_E);
      chk(mem_we_n && mem_dq_oe && !mem_ce_n, "R4 hold cycle", 32'({mem_we_n, mem_dq_oe, mem_ce_n}), 3'b110);
      if (be[0]) shadow[a[5:0]][7:0]  = wd[7:0];
      if (be[1]) shadow[a[5:0]][15:8] = wd[15:8];
    end
    @(negedge clk);
    chk(!rsp_ack, "R10 ack one cycle", 32'(rsp_ack), 0);
    chk(req_ready && mem_ce_n && !mem_dq_oe, "R9 standby after command",
        32'({req_ready, mem_ce_n, mem_dq_oe}), 3'b110);
    if (inject) begin
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        chk(mem_ce_n && req_ready, "R8 busy request ignored", 32'({mem_ce_n, req_ready}), 3);
      end
    end
  endtask

  function automatic logic [18:0] addr_of(input int i);
    return {13'(i * 13'h1357), 6'(i * 5 + 1)};
  endfunction

  initial begin
    total = 0; bad = 0; cyc = 0; rd_cnt = 0;
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    for (int i = 0; i < 64; i++) begin
      mem[i] = init_word(i);
      shadow[i] = init_word(i);
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n, "R1 controls idle",
        32'({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}), 5'h1F);
    chk(!mem_dq_oe && !rsp_ack && req_ready, "R1 handshake idle",
        32'({mem_dq_oe, rsp_ack, req_ready}), 3'b001);

    for (int i = 0; i < 8; i++) do_cmd(1'b0, addr_of(i), 16'h0, 2'b11, 1'b0);
    for (int i = 0; i < 8; i++) do_cmd(1'b1, addr_of(i), 16'(i * 16'h1111) ^ 16'hC3A5, 2'(i), 1'b0);
    for (int i = 0; i < 8; i++)
      for (int b = 0; b < 4; b++) do_cmd(1'b0, addr_of(i), 16'h0, 2'(b), 1'b0);
    // back-to-back read then write then read, with a busy request injected
    do_cmd(1'b0, addr_of(3), 16'h0, 2'b11, 1'b1);
    do_cmd(1'b1, addr_of(3), 16'hBEEF, 2'b11, 1'b1);
    do_cmd(1'b0, addr_of(3), 16'h0, 2'b11, 1'b0);
    do_cmd(1'b0, addr_of(3) ^ 19'h00011, 16'h0, 2'b11, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule